// File: doc/BRIEF.md
# Trigger Matching Latency Buffer

This block pairs time-tagged detector hits with delayed triggers. Each hit comes in already carrying a coarse time tag and a channel number. It is written into a ring-shaped latency buffer, and only on cycles where a hit is actually presented. Each trigger comes in carrying its own coarse tag. A programmable latency is subtracted from that tag, which gives the start of a match window whose width is also programmable. Every buffered hit whose tag falls inside that window is copied into an output FIFO. The copied hits sit between a header word and a trailer word.

Triggers wait in a small queue and are served one at a time, oldest first. Matching only reads the latency buffer and never removes anything from it, so windows that overlap can each claim the same hit. Hits that have become too old to match any later trigger are removed from the head of the buffer while no trigger is pending. All tag arithmetic is done modulo the coarse counter range, so windows that cross the counter wrap match correctly. When a matched hit finds the output FIFO full, the hit is dropped and the event trailer carries an error bit. The header and trailer themselves always wait for space and are never lost.

Top module: `tm_trigger_matcher`

## Requirements
- R1: A hit is stored only on a cycle with `hit_valid` high. A hit presented while the latency buffer already holds `BUF_DEPTH` entries is not stored.
- R2: A stored hit with tag h belongs to the event for trigger tag T exactly when ((h − (T − latency)) mod 2^TAG_W) ≤ win_width.
- R3: Matching gives the same result when the window or the hits straddle the wrap of the coarse count from 2^TAG_W−1 to 0.
- R4: The output word's top two bits give its kind: 01 header, 10 hit, 11 trailer. A header carries the trigger tag in its low TAG_W bits. A hit carries {channel, tag} below the kind. A trailer carries an error bit at position TAG_W+CH_W−1, zeros below it down to TAG_W, and the count of hit words emitted in its low TAG_W bits. Hits appear in the order they were stored.
- R5: A hit that lies inside the windows of two triggers is emitted in both events.
- R6: Queued triggers produce their events in arrival order, and each event's header, hits and trailer are contiguous.
- R7: A matched hit that meets a full output FIFO is dropped and sets the trailer error bit. The trailer count then holds only the hits actually emitted, and the header and trailer are still emitted.
- R8: While no trigger is queued or being served, a head entry whose age (coarse_now − tag, modulo 2^TAG_W) exceeds latency + win_width is removed. A later trigger aimed at it yields an event with no hits.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold.
- R10: After reset, the output FIFO is empty and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| coarse_now | input | TAG_W | Current coarse time count |
| hit_valid | input | 1 | A hit is presented this cycle |
| hit_tag | input | TAG_W | Time tag of the presented hit |
| hit_chan | input | CH_W | Channel of the presented hit |
| trig_valid | input | 1 | A trigger is presented this cycle |
| trig_tag | input | TAG_W | Time tag of the presented trigger |
| latency | input | TAG_W | Offset subtracted from a trigger tag |
| win_width | input | TAG_W | Width of the match window |
| out_ready | input | 1 | Consumer accepts the output word |
| out_valid | output | 1 | Output word available |
| out_data | output | 2+CH_W+TAG_W | Header, hit or trailer word |

## Verification
The bench first aims a window so that it covers some cycles with hits and some idle cycles. It then serves two triggers whose windows overlap, places hits and a window across the counter wrap, and fills the latency buffer past its capacity. A design that stored data on empty cycles would emit extra hit words. A design that compared tags without modular arithmetic would lose the hits near the wrap. A design that consumed hits while matching would leave the second overlapping event short. The bench also holds the consumer off so that the output FIFO overflows in the middle of an event. A design that dropped the trailer or the header there, or failed to flag the loss, would break the framing or report a wrong count. Finally, the bench lets a hit age past the keep span and aims a trigger at it. A design that never discarded stale hits would still emit that hit.

// File: rtl/tm_pkg.sv
package tm_pkg;

   typedef enum logic [1:0] {
      WK_NONE = 2'd0,
      WK_HEAD = 2'd1,
      WK_HIT  = 2'd2,
      WK_TAIL = 2'd3
   } word_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_HEAD = 2'd1,
      ST_SCAN = 2'd2,
      ST_TAIL = 2'd3
   } match_state_e;

   function automatic bit is_pow2(int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/tm_sync_fifo.sv
module tm_sync_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic         full,
   output logic         empty,
   output logic [W-1:0] dout
);

   generate
      if (DEPTH == 1) begin : g_reg
         logic [W-1:0] q;
         logic         v;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   v <= 1'b0;
            else if (v)   begin if (pop) v <= 1'b0; end
            else if (push) v <= 1'b1;
         end
         always_ff @(posedge clk) begin
            if (!v && push) q <= din;
         end
         assign full  = v;
         assign empty = !v;
         assign dout  = q;
      end else begin : g_ring
         localparam int AW = $clog2(DEPTH);
         logic [W-1:0] mem [DEPTH];
         logic [AW:0]  wp, rp;
         logic         full_i, empty_i;
         assign full_i  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
         assign empty_i = (wp == rp);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wp <= '0;
               rp <= '0;
            end else begin
               if (push && !full_i) wp <= wp + 1'b1;
               if (pop && !empty_i) rp <= rp + 1'b1;
            end
         end
         always_ff @(posedge clk) begin
            if (push && !full_i) mem[wp[AW-1:0]] <= din;
         end
         assign full  = full_i;
         assign empty = empty_i;
         assign dout  = mem[rp[AW-1:0]];
      end
   endgenerate

endmodule

// File: rtl/tm_hit_ring.sv
module tm_hit_ring #(
   parameter int TAG_W = 11,
   parameter int CH_W  = 6,
   parameter int DEPTH = 64,
   localparam int HIT_W = CH_W + TAG_W,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [HIT_W-1:0] wr_hit,
   input  logic             drop,
   input  logic [AW:0]      rd_ptr,
   output logic [HIT_W-1:0] rd_hit,
   output logic [TAG_W-1:0] head_tag,
   output logic [AW:0]      head_ptr,
   output logic [AW:0]      tail_ptr,
   output logic             full,
   output logic             empty
);

   logic [HIT_W-1:0] mem [DEPTH];
   logic [AW:0]      wp, rp;
   logic [HIT_W-1:0] head_hit;

   assign full     = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
   assign empty    = (wp == rp);
   assign head_ptr = rp;
   assign tail_ptr = wp;
   assign rd_hit   = mem[rd_ptr[AW-1:0]];
   assign head_hit = mem[rp[AW-1:0]];
   assign head_tag = head_hit[TAG_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0;
         rp <= '0;
      end else begin
         if (wr_en && !full) wp <= wp + 1'b1;
         if (drop && !empty) rp <= rp + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en && !full) mem[wp[AW-1:0]] <= wr_hit;
   end

   logic unused_head;
   assign unused_head = ^head_hit[HIT_W-1:TAG_W];

endmodule

// File: rtl/tm_trigger_matcher.sv
module tm_trigger_matcher
   import tm_pkg::*;
#(
   parameter int TAG_W      = 11,
   parameter int CH_W       = 6,
   parameter int BUF_DEPTH  = 64,
   parameter int TRIG_DEPTH = 4,
   parameter int OUT_DEPTH  = 16,
   localparam int HIT_W  = CH_W + TAG_W,
   localparam int WORD_W = 2 + HIT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TAG_W-1:0]  coarse_now,
   input  logic              hit_valid,
   input  logic [TAG_W-1:0]  hit_tag,
   input  logic [CH_W-1:0]   hit_chan,
   input  logic              trig_valid,
   input  logic [TAG_W-1:0]  trig_tag,
   input  logic [TAG_W-1:0]  latency,
   input  logic [TAG_W-1:0]  win_width,
   input  logic              out_ready,
   output logic              out_valid,
   output logic [WORD_W-1:0] out_data
);

   localparam int PW = $clog2(BUF_DEPTH) + 1;

   generate
      if (!is_pow2(BUF_DEPTH) || BUF_DEPTH < 2) begin : g_bad_buf
         $error("BUF_DEPTH must be a power of two of at least 2");
      end
      if (!is_pow2(TRIG_DEPTH)) begin : g_bad_trig
         $error("TRIG_DEPTH must be a power of two");
      end
      if (!is_pow2(OUT_DEPTH)) begin : g_bad_out
         $error("OUT_DEPTH must be a power of two");
      end
      if (CH_W < 2 || TAG_W < 4) begin : g_bad_width
         $error("CH_W must be at least 2 and TAG_W at least 4");
      end
   endgenerate

   match_state_e     state;
   logic [TAG_W-1:0] evt_tag;
   logic [PW-1:0]    scan_ptr;
   logic [TAG_W-1:0] hit_cnt;
   logic             lost;

   // latency buffer
   logic [HIT_W-1:0] scan_hit;
   logic [TAG_W-1:0] head_tag;
   logic [PW-1:0]    head_ptr, tail_ptr;
   logic             ring_full, ring_empty, ring_drop;

   // trigger queue
   logic             trig_full, trig_empty;
   logic [TAG_W-1:0] trig_head;

   // output queue
   logic              out_full, out_empty, out_push;
   logic [WORD_W-1:0] out_word;

   tm_hit_ring #(.TAG_W(TAG_W), .CH_W(CH_W), .DEPTH(BUF_DEPTH)) u_ring (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (hit_valid),
      .wr_hit   ({hit_chan, hit_tag}),
      .drop     (ring_drop),
      .rd_ptr   (scan_ptr),
      .rd_hit   (scan_hit),
      .head_tag (head_tag),
      .head_ptr (head_ptr),
      .tail_ptr (tail_ptr),
      .full     (ring_full),
      .empty    (ring_empty)
   );

   tm_sync_fifo #(.W(TAG_W), .DEPTH(TRIG_DEPTH)) u_trig_q (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (trig_valid && !trig_full),
      .din   (trig_tag),
      .pop   ((state == ST_IDLE) && !trig_empty),
      .full  (trig_full),
      .empty (trig_empty),
      .dout  (trig_head)
   );

   tm_sync_fifo #(.W(WORD_W), .DEPTH(OUT_DEPTH)) u_out_q (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (out_push),
      .din   (out_word),
      .pop   (out_ready && !out_empty),
      .full  (out_full),
      .empty (out_empty),
      .dout  (out_data)
   );

   assign out_valid = !out_empty;

   // stale-hit removal, only while nothing is waiting to be matched
   logic [TAG_W-1:0] head_age;
   logic [TAG_W:0]   keep_span;
   assign head_age  = coarse_now - head_tag;
   assign keep_span = {1'b0, latency} + {1'b0, win_width};
   assign ring_drop = (state == ST_IDLE) && trig_empty && !ring_empty &&
                      ({1'b0, head_age} > keep_span);

   // window compare, modulo the coarse range
   logic [TAG_W-1:0] win_base, scan_off;
   logic             in_win, scan_done;
   assign win_base  = evt_tag - latency;
   assign scan_off  = scan_hit[TAG_W-1:0] - win_base;
   assign in_win    = (scan_off <= win_width);
   assign scan_done = (scan_ptr == tail_ptr);

   always_comb begin
      out_push = 1'b0;
      out_word = '0;
      unique case (state)
         ST_HEAD: begin
            out_push = !out_full;
            out_word = {2'(WK_HEAD), {CH_W{1'b0}}, evt_tag};
         end
         ST_SCAN: begin
            out_push = !scan_done && in_win && !out_full;
            out_word = {2'(WK_HIT), scan_hit};
         end
         ST_TAIL: begin
            out_push = !out_full;
            out_word = {2'(WK_TAIL), lost, {(CH_W-1){1'b0}}, hit_cnt};
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         evt_tag  <= '0;
         scan_ptr <= '0;
         hit_cnt  <= '0;
         lost     <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: if (!trig_empty) begin
               evt_tag <= trig_head;
               state   <= ST_HEAD;
            end
            ST_HEAD: if (!out_full) begin
               scan_ptr <= head_ptr;
               hit_cnt  <= '0;
               lost     <= 1'b0;
               state    <= ST_SCAN;
            end
            ST_SCAN: if (scan_done) begin
               state <= ST_TAIL;
            end else begin
               scan_ptr <= scan_ptr + 1'b1;
               if (in_win) begin
                  if (out_full) lost    <= 1'b1;
                  else          hit_cnt <= hit_cnt + 1'b1;
               end
            end
            ST_TAIL: if (!out_full) state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/tm_matcher_chk.sv
module tm_matcher_chk
   import tm_pkg::*;
#(
   parameter int TAG_W = 11,
   parameter int CH_W  = 6,
   localparam int WORD_W = 2 + CH_W + TAG_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              out_valid,
   input logic              out_ready,
   input logic [WORD_W-1:0] out_data,
   input logic [TAG_W-1:0]  latency,
   input logic [TAG_W-1:0]  win_width
);

   logic [1:0]       kind;
   logic             take;
   logic             in_evt;
   logic [TAG_W-1:0] seen_tag, seen_cnt, hit_off;

   assign kind    = out_data[WORD_W-1 -: 2];
   assign take    = out_valid && out_ready;
   assign hit_off = out_data[TAG_W-1:0] - (seen_tag - latency);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_evt   <= 1'b0;
         seen_tag <= '0;
         seen_cnt <= '0;
      end else if (take) begin
         if (kind == WK_HEAD) begin
            in_evt   <= 1'b1;
            seen_tag <= out_data[TAG_W-1:0];
            seen_cnt <= '0;
         end else if (kind == WK_HIT) begin
            seen_cnt <= seen_cnt + 1'b1;
         end else if (kind == WK_TAIL) begin
            in_evt <= 1'b0;
         end
      end
   end

   // R9
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data));

   // R4
   word_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> kind != 2'b00);

   // R6
   head_framing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take && kind == WK_HEAD |-> !in_evt);

   // R6
   body_framing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take && (kind == WK_HIT || kind == WK_TAIL) |-> in_evt);

   // R2
   hit_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take && kind == WK_HIT |-> hit_off <= win_width);

   // R7
   tail_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take && kind == WK_TAIL |-> out_data[TAG_W-1:0] == seen_cnt);

endmodule

bind tm_trigger_matcher tm_matcher_chk #(.TAG_W(TAG_W), .CH_W(CH_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_data  (out_data),
   .latency   (latency),
   .win_width (win_width)
);

// File: tb/tb_tm_trigger_matcher.sv
module tb_tm_trigger_matcher;

   localparam int TAG_W = 11;
   localparam int CH_W  = 4;
   localparam int BUF   = 16;
   localparam int WW    = 2 + CH_W + TAG_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [TAG_W-1:0] now, start_now = '0;
   logic hit_valid = 1'b0, trig_valid = 1'b0, out_ready = 1'b1;
   logic [TAG_W-1:0] hit_tag = '0, trig_tag = '0, lat = 11'd20, win = 11'd6;
   logic [CH_W-1:0]  hit_chan = '0;
   logic out_valid;
   logic [WW-1:0] out_data;

   int checks = 0, fails = 0, cyc = 0;
   logic [WW-1:0] got[$], exp_q[$];
   logic [TAG_W-1:0] h_tag[64];
   logic [CH_W-1:0]  h_ch[64];
   bit               h_st[64];
   int nh = 0, nstored = 0;

   always #4 clk = ~clk;

   always @(posedge clk or negedge rst_n)
      if (!rst_n) now <= start_now; else now <= now + 1'b1;

   tm_trigger_matcher #(.TAG_W(TAG_W), .CH_W(CH_W), .BUF_DEPTH(BUF),
                        .TRIG_DEPTH(4), .OUT_DEPTH(4)) dut (
      .clk(clk), .rst_n(rst_n), .coarse_now(now),
      .hit_valid(hit_valid), .hit_tag(hit_tag), .hit_chan(hit_chan),
      .trig_valid(trig_valid), .trig_tag(trig_tag),
      .latency(lat), .win_width(win),
      .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data));

   always @(negedge clk) begin
      #3;
      if (rst_n && out_valid && out_ready) got.push_back(out_data);
   end

   task automatic check(bit ok, string req, logic [WW-1:0] act, logic [WW-1:0] expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   task automatic do_reset(logic [TAG_W-1:0] s);
      @(negedge clk);
      rst_n = 1'b0; start_now = s; hit_valid = 0; trig_valid = 0; out_ready = 1;
      got.delete(); exp_q.delete(); nh = 0; nstored = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic hit_cycle(bit v, logic [CH_W-1:0] ch);
      @(negedge clk);
      hit_valid = v; hit_tag = now; hit_chan = ch;
      if (v) begin
         h_tag[nh] = now; h_ch[nh] = ch; h_st[nh] = (nstored < BUF);
         if (nstored < BUF) nstored++;
         nh++;
      end
   endtask

   task automatic trig_cycle(bit v, logic [TAG_W-1:0] t);
      @(negedge clk);
      hit_valid = 0; trig_valid = v; trig_tag = t;
   endtask

   // expected event from R2/R4 with no output loss
   task automatic add_event(logic [TAG_W-1:0] t);
      logic [TAG_W-1:0] cnt = '0;
      exp_q.push_back({2'b01, {CH_W{1'b0}}, t});
      for (int k = 0; k < nh; k++) begin
         logic [TAG_W-1:0] d = h_tag[k] - (t - lat);
         if (h_st[k] && d <= win) begin
            exp_q.push_back({2'b10, h_ch[k], h_tag[k]});
            cnt++;
         end
      end
      exp_q.push_back({2'b11, 1'b0, {(CH_W-1){1'b0}}, cnt});
   endtask

   task automatic compare(string req, int wait_cyc);
      repeat (wait_cyc) @(negedge clk);
      check(got.size() == exp_q.size(), {req, " word count"}, WW'(got.size()), WW'(exp_q.size()));
      for (int k = 0; k < exp_q.size(); k++) begin
         logic [WW-1:0] a = (k < got.size()) ? got[k] : '1;
         check(a == exp_q[k], req, a, exp_q[k]);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         checks++; fails++;
         $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      // R10: empty output after reset
      do_reset(11'd50);
      repeat (2) @(negedge clk);
      #3 check(out_valid == 1'b0, "R10 reset", WW'(out_valid), '0);

      // R1 R2 R4: idle cycles inside the window add nothing
      do_reset(11'd100);
      for (int i = 0; i < 12; i++) hit_cycle((i % 3) != 1, CH_W'(i));
      trig_cycle(1, h_tag[0] + 11'd22);
      add_event(h_tag[0] + 11'd22);
      trig_cycle(0, '0);
      compare("R1 R2 R4 sparse hits", 80);

      // R5 R6: overlapping windows served in order
      do_reset(11'd300);
      for (int i = 0; i < 12; i++) hit_cycle(1, CH_W'(i));
      trig_cycle(1, h_tag[0] + 11'd21);
      trig_cycle(1, h_tag[0] + 11'd24);
      add_event(h_tag[0] + 11'd21);
      add_event(h_tag[0] + 11'd24);
      trig_cycle(0, '0);
      compare("R5 R6 overlap", 100);

      // R3: hits and window across the counter wrap
      do_reset(11'd2040);
      for (int i = 0; i < 12; i++) hit_cycle((i % 2) == 0, CH_W'(i));
      trig_cycle(1, h_tag[0] + 11'd23);
      add_event(h_tag[0] + 11'd23);
      trig_cycle(0, '0);
      compare("R3 wrap", 80);

      // R1: buffer capacity, later hits not stored
      lat = 11'd40; win = 11'd30;
      do_reset(11'd500);
      for (int i = 0; i < 20; i++) hit_cycle(1, CH_W'(i));
      trig_cycle(1, h_tag[0] + 11'd40);
      add_event(h_tag[0] + 11'd40);
      trig_cycle(0, '0);
      compare("R1 capacity", 100);

      // R7 R9: output overflow inside an event
      lat = 11'd20; win = 11'd6;
      do_reset(11'd700);
      out_ready = 0;
      for (int i = 0; i < 6; i++) hit_cycle(1, CH_W'(i + 3));
      trig_cycle(1, h_tag[0] + 11'd20);
      trig_cycle(0, '0);
      repeat (40) @(negedge clk);
      #3 check(out_valid == 1'b1, "R9 valid held", WW'(out_valid), WW'(1));
      check(out_data == {2'b01, {CH_W{1'b0}}, h_tag[0] + 11'd20}, "R9 data held",
            out_data, {2'b01, {CH_W{1'b0}}, h_tag[0] + 11'd20});
      @(negedge clk);
      #3 check(out_data == {2'b01, {CH_W{1'b0}}, h_tag[0] + 11'd20}, "R9 data stable",
               out_data, {2'b01, {CH_W{1'b0}}, h_tag[0] + 11'd20});
      exp_q.push_back({2'b01, {CH_W{1'b0}}, h_tag[0] + 11'd20});
      for (int k = 0; k < 3; k++) exp_q.push_back({2'b10, h_ch[k], h_tag[k]});
      exp_q.push_back({2'b11, 1'b1, {(CH_W-1){1'b0}}, 11'd3});
      @(negedge clk);
      out_ready = 1;
      compare("R7 overflow", 40);

      // R8: stale hit discarded, fresh hit still matched
      do_reset(11'd900);
      hit_cycle(1, 4'd5);
      hit_cycle(0, '0);
      repeat (40) @(negedge clk);
      trig_cycle(1, h_tag[0] + 11'd20);
      trig_cycle(0, '0);
      exp_q.push_back({2'b01, {CH_W{1'b0}}, h_tag[0] + 11'd20});
      exp_q.push_back({2'b11, 1'b0, {(CH_W-1){1'b0}}, 11'd0});
      repeat (20) @(negedge clk);
      nh = 0; nstored = 0;
      hit_cycle(1, 4'd9);
      trig_cycle(1, h_tag[0] + 11'd20);
      add_event(h_tag[0] + 11'd20);
      trig_cycle(0, '0);
      compare("R8 discard", 40);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule